// File: doc/BRIEF.md
# Element-Group Vector Length Controller

This block serves two jobs for vector instructions that process power-of-two groups of elements. On its configuration channel it receives a requested application vector length (AVL), the current VLMAX and the base-2 logarithm of the largest group size the implementation supports. It returns the granted vector length. When the request exceeds VLMAX, the grant is shaped so that a strip-mined loop never leaves an element group split between two iterations.

On its issue channel it receives the group size that an instruction encodes, together with the current vl and VLMAX. It reports whether the instruction must raise an illegal-instruction exception or whether the vl is reserved for that group size. Both channels use a valid/ready handshake. Each channel returns exactly one registered result for every accepted request. The two channels are independent, and both may fire in the same clock cycle.

Top module: `egrp_vl_ctrl`

## Requirements
- R1: A configuration request with AVL less than or equal to VLMAX grants vl equal to AVL, including an AVL of zero.
- R2: A configuration request with AVL above VLMAX, where VLMAX is already a multiple of 2^lg2 (lg2 being `cfg_grp_max_lg2`), grants VLMAX.
- R3: A configuration request with AVL above VLMAX, where VLMAX is not such a multiple, grants VLMAX rounded down to the nearest nonzero multiple of 2^lg2.
- R4: If that rounding would give zero, because VLMAX is below 2^lg2, the grant is VLMAX.
- R5: An issued group size, given as a plain binary element count, that is zero or not a power of two raises the illegal flag.
- R6: An issued group size greater than the issue-time VLMAX raises the illegal flag.
- R7: For a legal group size, the reserved flag is raised exactly when vl is not a whole multiple of the group size. The test looks only at the low log2(size) bits of vl.
- R8: A group size of 1 with a nonzero VLMAX never raises either flag, whatever the vl.
- R9: The illegal flag takes priority: when it is set, the reserved flag is clear.
- R10: Each response valid rises in the cycle after its channel's handshake and stays low in any cycle that follows no handshake. The two channels do not affect each other.
- R11: While reset is asserted, both ready outputs and both response valids are low. Both readies are high from the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_valid | input | 1 | Configuration request present |
| cfg_ready | output | 1 | Configuration request accepted when high |
| cfg_avl | input | AVL_W | Requested application vector length |
| cfg_vlmax | input | VL_W | Current VLMAX |
| cfg_grp_max_lg2 | input | LG_W | log2 of the largest supported group size |
| cfg_rsp_valid | output | 1 | Granted length is valid |
| cfg_rsp_vl | output | VL_W | Granted vector length |
| iss_valid | input | 1 | Issue check request present |
| iss_ready | output | 1 | Issue check request accepted when high |
| iss_grp_size | input | EGS_W | Element count per group encoded by the instruction |
| iss_vl | input | VL_W | Current vl |
| iss_vlmax | input | VL_W | Current VLMAX |
| iss_rsp_valid | output | 1 | Check result is valid |
| iss_rsp_illegal | output | 1 | Illegal-instruction exception |
| iss_rsp_reserved | output | 1 | vl is reserved for this group size |

## Verification
A length grant and an instruction check can complete in the same cycle, because the two channels have separate handshakes and separate result registers. Every row of the stimulus table drives a configuration request and an issue request together, back to back, so both channels are loaded on every cycle of the walk. Each channel's result is compared with its own precomputed expectation one edge later. Directed steps then fire one channel alone to show that the other channel's response valid stays low.

// File: rtl/egrp_vl_pkg.sv
package egrp_vl_pkg;

   // Outcome of an issue-time group check; the order encodes priority.
   typedef enum logic [1:0] {
      VERDICT_OK       = 2'd0,
      VERDICT_RESERVED = 2'd1,
      VERDICT_ILLEGAL  = 2'd2
   } grp_verdict_e;

   // Returns the ceiling log2 of a positive integer.
   function automatic int unsigned lg2_ceil(input int unsigned n);
      int unsigned r;
      r = 0;
      while ((32'd1 << r) < n) r++;
      return r;
   endfunction

   // Returns 1 when n is a nonzero power of two.
   function automatic bit is_pow2(input int unsigned n);
      return (n != 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/egrp_lowmask.sv
// Expands a log2 value into a thermometer mask of the low bits it covers.
module egrp_lowmask #(
   parameter int unsigned W    = 10,
   parameter int unsigned LG_W = 3
) (
   input  logic [LG_W-1:0] lg,
   output logic [W-1:0]    mask
);

   logic [31:0] lg_wide;
   assign lg_wide = {{(32-LG_W){1'b0}}, lg};

   for (genvar i = 0; i < W; i++) begin : g_bit
      localparam logic [31:0] IDX = i;
      assign mask[i] = (lg_wide > IDX);
   end

endmodule

// File: rtl/egrp_vl_grant.sv
// Combinational length grant: the whole AVL when it fits, otherwise a
// group-aligned VLMAX.
module egrp_vl_grant #(
   parameter int unsigned AVL_W = 16,
   parameter int unsigned VL_W  = 10,
   parameter int unsigned LG_W  = 3
) (
   input  logic [AVL_W-1:0] avl,
   input  logic [VL_W-1:0]  vlmax,
   input  logic [LG_W-1:0]  grp_max_lg2,
   output logic [VL_W-1:0]  grant
);

   logic [VL_W-1:0]  low_mask;
   logic [VL_W-1:0]  aligned;
   logic [AVL_W-1:0] vlmax_wide;
   logic             over;

   egrp_lowmask #(.W(VL_W), .LG_W(LG_W)) u_mask (
      .lg   (grp_max_lg2),
      .mask (low_mask)
   );

   assign vlmax_wide = AVL_W'(vlmax);
   assign over       = (avl > vlmax_wide);
   // Clearing the low bits rounds down to a multiple of the largest group.
   assign aligned    = vlmax & ~low_mask;

   always_comb begin
      if (!over) begin
         grant = avl[VL_W-1:0];
      end else if (aligned == '0) begin
         grant = vlmax;
      end else begin
         grant = aligned;
      end
   end

endmodule

// File: rtl/egrp_issue_check.sv
// Combinational group-size legality and vl multiple test.
module egrp_issue_check
   import egrp_vl_pkg::*;
#(
   parameter int unsigned VL_W  = 10,
   parameter int unsigned EGS_W = 6
) (
   input  logic [EGS_W-1:0] grp_size,
   input  logic [VL_W-1:0]  vl,
   input  logic [VL_W-1:0]  vlmax,
   output grp_verdict_e     verdict
);

   localparam int unsigned CW = (VL_W > EGS_W) ? VL_W : EGS_W;

   logic [CW-1:0] size_c;
   logic [CW-1:0] vl_c;
   logic [CW-1:0] vlmax_c;
   logic [CW-1:0] size_m1;
   logic          pow2_ok;
   logic          fits;
   logic          aligned;

   // Operands are widened to a common width; generate picks the side to pad.
   if (VL_W >= EGS_W) begin : g_pad_size
      assign size_c  = CW'(grp_size);
      assign vl_c    = vl;
      assign vlmax_c = vlmax;
   end else begin : g_pad_vl
      assign size_c  = grp_size;
      assign vl_c    = CW'(vl);
      assign vlmax_c = CW'(vlmax);
   end

   assign size_m1 = size_c - CW'(1);
   assign pow2_ok = (size_c != '0) && ((size_c & size_m1) == '0);
   assign fits    = (size_c <= vlmax_c);
   // For a power-of-two size, size-1 covers exactly the low log2(size) bits.
   assign aligned = ((vl_c & size_m1) == '0);

   always_comb begin
      if (!pow2_ok || !fits) begin
         verdict = VERDICT_ILLEGAL;
      end else if (!aligned) begin
         verdict = VERDICT_RESERVED;
      end else begin
         verdict = VERDICT_OK;
      end
   end

endmodule

// File: rtl/egrp_vl_ctrl.sv
// Element-group vector length controller: two independent request channels,
// one registered result per accepted request.
module egrp_vl_ctrl
   import egrp_vl_pkg::*;
#(
   parameter int unsigned AVL_W     = 16,
   parameter int unsigned VLMAX_LIM = 512,
   parameter int unsigned EGS_LIM   = 32,
   localparam int unsigned VL_W     = lg2_ceil(VLMAX_LIM + 1),
   localparam int unsigned EGS_W    = lg2_ceil(EGS_LIM) + 1,
   localparam int unsigned LG_W     = lg2_ceil(lg2_ceil(EGS_LIM) + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_valid,
   output logic             cfg_ready,
   input  logic [AVL_W-1:0] cfg_avl,
   input  logic [VL_W-1:0]  cfg_vlmax,
   input  logic [LG_W-1:0]  cfg_grp_max_lg2,
   output logic             cfg_rsp_valid,
   output logic [VL_W-1:0]  cfg_rsp_vl,
   input  logic             iss_valid,
   output logic             iss_ready,
   input  logic [EGS_W-1:0] iss_grp_size,
   input  logic [VL_W-1:0]  iss_vl,
   input  logic [VL_W-1:0]  iss_vlmax,
   output logic             iss_rsp_valid,
   output logic             iss_rsp_illegal,
   output logic             iss_rsp_reserved
);

   // Elaboration-time parameter checks.
   if (!is_pow2(VLMAX_LIM)) begin : g_bad_vlmax
      $error("VLMAX_LIM must be a power of two");
   end
   if (!is_pow2(EGS_LIM) || EGS_LIM > VLMAX_LIM) begin : g_bad_egs
      $error("EGS_LIM must be a power of two no larger than VLMAX_LIM");
   end
   if (AVL_W < VL_W) begin : g_bad_avl
      $error("AVL_W must hold any VLMAX value");
   end

   logic            ready_q;
   logic            cfg_fire;
   logic            iss_fire;
   logic [VL_W-1:0] grant;
   grp_verdict_e    verdict;

   logic            cfg_rsp_valid_q;
   logic [VL_W-1:0] cfg_rsp_vl_q;
   logic            iss_rsp_valid_q;
   logic            iss_ill_q;
   logic            iss_res_q;

   assign cfg_ready = ready_q;
   assign iss_ready = ready_q;
   assign cfg_fire  = cfg_valid && ready_q;
   assign iss_fire  = iss_valid && ready_q;

   egrp_vl_grant #(.AVL_W(AVL_W), .VL_W(VL_W), .LG_W(LG_W)) u_grant (
      .avl         (cfg_avl),
      .vlmax       (cfg_vlmax),
      .grp_max_lg2 (cfg_grp_max_lg2),
      .grant       (grant)
   );

   egrp_issue_check #(.VL_W(VL_W), .EGS_W(EGS_W)) u_check (
      .grp_size (iss_grp_size),
      .vl       (iss_vl),
      .vlmax    (iss_vlmax),
      .verdict  (verdict)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready_q         <= 1'b0;
         cfg_rsp_valid_q <= 1'b0;
         cfg_rsp_vl_q    <= '0;
         iss_rsp_valid_q <= 1'b0;
         iss_ill_q       <= 1'b0;
         iss_res_q       <= 1'b0;
      end else begin
         ready_q         <= 1'b1;
         cfg_rsp_valid_q <= cfg_fire;
         iss_rsp_valid_q <= iss_fire;
         if (cfg_fire) begin
            cfg_rsp_vl_q <= grant;
         end
         if (iss_fire) begin
            iss_ill_q <= (verdict == VERDICT_ILLEGAL);
            iss_res_q <= (verdict == VERDICT_RESERVED);
         end
      end
   end

   assign cfg_rsp_valid    = cfg_rsp_valid_q;
   assign cfg_rsp_vl       = cfg_rsp_vl_q;
   assign iss_rsp_valid    = iss_rsp_valid_q;
   assign iss_rsp_illegal  = iss_ill_q;
   assign iss_rsp_reserved = iss_res_q;

endmodule

// File: rtl/egrp_vl_ctrl_chk.sv
// Temporal checks on the controller ports, bound to every instance.
module egrp_vl_ctrl_chk #(
   parameter int unsigned AVL_W = 16,
   parameter int unsigned VL_W  = 10,
   parameter int unsigned EGS_W = 6,
   parameter int unsigned LG_W  = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_valid,
   input logic             cfg_ready,
   input logic [AVL_W-1:0] cfg_avl,
   input logic [VL_W-1:0]  cfg_vlmax,
   input logic [LG_W-1:0]  cfg_grp_max_lg2,
   input logic             cfg_rsp_valid,
   input logic [VL_W-1:0]  cfg_rsp_vl,
   input logic             iss_valid,
   input logic             iss_ready,
   input logic [EGS_W-1:0] iss_grp_size,
   input logic [VL_W-1:0]  iss_vl,
   input logic [VL_W-1:0]  iss_vlmax,
   input logic             iss_rsp_valid,
   input logic             iss_rsp_illegal,
   input logic             iss_rsp_reserved
);

   localparam int unsigned CW = (VL_W > EGS_W) ? VL_W : EGS_W;

   logic cfg_hs;
   logic iss_hs;
   assign cfg_hs = cfg_valid && cfg_ready;
   assign iss_hs = iss_valid && iss_ready;

   assert_fit_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_hs && cfg_avl <= AVL_W'(cfg_vlmax)) |=>
         (cfg_rsp_vl == $past(cfg_avl[VL_W-1:0])));

   // R2, R3, R4: an oversize request yields VLMAX or a nonzero group multiple.
   assert_over_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_hs && cfg_avl > AVL_W'(cfg_vlmax)) |=>
         ((cfg_rsp_vl == $past(cfg_vlmax)) ||
          ((cfg_rsp_vl != '0) && (cfg_rsp_vl <= $past(cfg_vlmax)) &&
           ((cfg_rsp_vl & ((VL_W'(1) << $past(cfg_grp_max_lg2)) - VL_W'(1))) == '0))));

   assert_size_over_vlmax_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_hs && CW'(iss_grp_size) > CW'(iss_vlmax)) |=> iss_rsp_illegal);

   assert_zero_size_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_hs && iss_grp_size == '0) |=> iss_rsp_illegal);

   assert_unit_group_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_hs && iss_grp_size == EGS_W'(1) && iss_vlmax != '0) |=>
         (!iss_rsp_illegal && !iss_rsp_reserved));

   assert_flag_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
      iss_rsp_valid |-> !(iss_rsp_illegal && iss_rsp_reserved));

   assert_cfg_rsp_timing_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_hs |=> cfg_rsp_valid);

   assert_cfg_rsp_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_hs |=> !cfg_rsp_valid);

   assert_iss_rsp_timing_R10: assert property (@(posedge clk) disable iff (!rst_n)
      iss_hs |=> iss_rsp_valid);

   assert_iss_rsp_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !iss_hs |=> !iss_rsp_valid);

   assert_ready_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_ready |=> (cfg_ready && iss_ready));

endmodule

bind egrp_vl_ctrl egrp_vl_ctrl_chk #(
   .AVL_W (AVL_W),
   .VL_W  (VL_W),
   .EGS_W (EGS_W),
   .LG_W  (LG_W)
) u_egrp_vl_ctrl_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .cfg_valid        (cfg_valid),
   .cfg_ready        (cfg_ready),
   .cfg_avl          (cfg_avl),
   .cfg_vlmax        (cfg_vlmax),
   .cfg_grp_max_lg2  (cfg_grp_max_lg2),
   .cfg_rsp_valid    (cfg_rsp_valid),
   .cfg_rsp_vl       (cfg_rsp_vl),
   .iss_valid        (iss_valid),
   .iss_ready        (iss_ready),
   .iss_grp_size     (iss_grp_size),
   .iss_vl           (iss_vl),
   .iss_vlmax        (iss_vlmax),
   .iss_rsp_valid    (iss_rsp_valid),
   .iss_rsp_illegal  (iss_rsp_illegal),
   .iss_rsp_reserved (iss_rsp_reserved)
);

// File: tb/tb_egrp_vl_ctrl.sv
module tb_egrp_vl_ctrl;

   localparam int unsigned AVL_W = 16;
   localparam int unsigned VL_W  = 10;
   localparam int unsigned EGS_W = 6;
   localparam int unsigned LG_W  = 3;

   typedef struct packed {
      logic [AVL_W-1:0] avl;
      logic [VL_W-1:0]  vlmax;
      logic [LG_W-1:0]  lg;
      logic [VL_W-1:0]  exp_vl;
      logic [EGS_W-1:0] egs;
      logic [VL_W-1:0]  ivl;
      logic [VL_W-1:0]  ivlmax;
      logic             ill;
      logic             res;
   } vec_t;

   function automatic vec_t mk(input int avl, input int vlmax, input int lg,
                               input int exp_vl, input int egs, input int ivl,
                               input int ivlmax, input int ill, input int res);
      vec_t v;
      v.avl    = AVL_W'(avl);
      v.vlmax  = VL_W'(vlmax);
      v.lg     = LG_W'(lg);
      v.exp_vl = VL_W'(exp_vl);
      v.egs    = EGS_W'(egs);
      v.ivl    = VL_W'(ivl);
      v.ivlmax = VL_W'(ivlmax);
      v.ill    = ill[0];
      v.res    = res[0];
      return v;
   endfunction

   localparam int NV = 12;
   // Configuration side | issue side, both driven in the same cycle.
   localparam vec_t TBL [0:NV-1] = '{
      mk(   10,  64, 2,  10,   1,   7,  64, 0, 0),  // R1 fit, R8 unit group
      mk(   64,  64, 3,  64,   4,  12,  64, 0, 0),  // R1 equal, R7 multiple
      mk(  100,  64, 3,  64,   4,  13,  64, 0, 1),  // R2 aligned, R7 reserved
      mk(  100,  60, 3,  56,   3,   8,  64, 1, 0),  // R3 round, R5 non-pow2
      mk( 1000,  37, 2,  36,   0,   0,  64, 1, 0),  // R3 round, R5 zero size
      mk(   50,   6, 3,   6,   8,   4,   6, 1, 0),  // R4 tiny, R6 + R9 priority
      mk(    9,   8, 4,   8,  16,  16,  16, 0, 0),  // R4 tiny, size == vlmax
      mk(65535, 512, 5, 512,  32,  96, 512, 0, 0),  // R2 max AVL
      mk(  300, 300, 5, 300,  32, 100, 512, 0, 1),  // R1 equal, R7 reserved
      mk(  301, 300, 5, 288,   6,  12, 300, 1, 0),  // R3 round, R5 non-pow2
      mk(    5,   3, 0,   3,   2,   2,   1, 1, 0),  // R2 lg zero, R6 over
      mk(    0,  16, 2,   0,   2,   3,  16, 0, 1)   // R1 zero AVL, R7 reserved
   };

   logic             clk;
   logic             rst_n;
   logic             cfg_valid;
   logic             cfg_ready;
   logic [AVL_W-1:0] cfg_avl;
   logic [VL_W-1:0]  cfg_vlmax;
   logic [LG_W-1:0]  cfg_grp_max_lg2;
   logic             cfg_rsp_valid;
   logic [VL_W-1:0]  cfg_rsp_vl;
   logic             iss_valid;
   logic             iss_ready;
   logic [EGS_W-1:0] iss_grp_size;
   logic [VL_W-1:0]  iss_vl;
   logic [VL_W-1:0]  iss_vlmax;
   logic             iss_rsp_valid;
   logic             iss_rsp_illegal;
   logic             iss_rsp_reserved;

   int  checks;
   int  errors;
   bit  finished;

   egrp_vl_ctrl dut (
      .clk              (clk),
      .rst_n            (rst_n),
      .cfg_valid        (cfg_valid),
      .cfg_ready        (cfg_ready),
      .cfg_avl          (cfg_avl),
      .cfg_vlmax        (cfg_vlmax),
      .cfg_grp_max_lg2  (cfg_grp_max_lg2),
      .cfg_rsp_valid    (cfg_rsp_valid),
      .cfg_rsp_vl       (cfg_rsp_vl),
      .iss_valid        (iss_valid),
      .iss_ready        (iss_ready),
      .iss_grp_size     (iss_grp_size),
      .iss_vl           (iss_vl),
      .iss_vlmax        (iss_vlmax),
      .iss_rsp_valid    (iss_rsp_valid),
      .iss_rsp_illegal  (iss_rsp_illegal),
      .iss_rsp_reserved (iss_rsp_reserved)
   );

   // 250 MHz clock.
   initial clk = 1'b0;
   always #2 clk = ~clk;

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL R10 watchdog act=hung exp=done");
         summary();
         $finish;
      end
   end

   initial begin
      checks          = 0;
      errors          = 0;
      finished        = 1'b0;
      rst_n           = 1'b0;
      cfg_valid       = 1'b0;
      cfg_avl         = '0;
      cfg_vlmax       = '0;
      cfg_grp_max_lg2 = '0;
      iss_valid       = 1'b0;
      iss_grp_size    = '0;
      iss_vl          = '0;
      iss_vlmax       = '0;

      // Reset state (R11).
      repeat (3) @(negedge clk);
      chk("R11", "cfg_ready in reset",     32'(cfg_ready),     32'd0);
      chk("R11", "iss_ready in reset",     32'(iss_ready),     32'd0);
      chk("R11", "cfg_rsp_valid in reset", 32'(cfg_rsp_valid), 32'd0);
      chk("R11", "iss_rsp_valid in reset", 32'(iss_rsp_valid), 32'd0);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      chk("R11", "cfg_ready after reset", 32'(cfg_ready), 32'd1);
      chk("R11", "iss_ready after reset", 32'(iss_ready), 32'd1);

      // Table walk: both channels loaded back to back on every cycle.
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         cfg_valid       = 1'b1;
         cfg_avl         = TBL[i].avl;
         cfg_vlmax       = TBL[i].vlmax;
         cfg_grp_max_lg2 = TBL[i].lg;
         iss_valid       = 1'b1;
         iss_grp_size    = TBL[i].egs;
         iss_vl          = TBL[i].ivl;
         iss_vlmax       = TBL[i].ivlmax;
         @(posedge clk);
         #1;
         chk("R10", $sformatf("row %0d cfg_rsp_valid", i), 32'(cfg_rsp_valid), 32'd1);
         chk("R10", $sformatf("row %0d iss_rsp_valid", i), 32'(iss_rsp_valid), 32'd1);
         chk("R1-4", $sformatf("row %0d granted vl", i), 32'(cfg_rsp_vl), 32'(TBL[i].exp_vl));
         chk("R5/R6", $sformatf("row %0d illegal", i), 32'(iss_rsp_illegal), 32'(TBL[i].ill));
         chk("R7/R9", $sformatf("row %0d reserved", i), 32'(iss_rsp_reserved), 32'(TBL[i].res));
      end

      // Idle cycle: no handshake on either channel (R10).
      @(negedge clk);
      cfg_valid = 1'b0;
      iss_valid = 1'b0;
      @(posedge clk);
      #1;
      chk("R10", "cfg_rsp_valid idle", 32'(cfg_rsp_valid), 32'd0);
      chk("R10", "iss_rsp_valid idle", 32'(iss_rsp_valid), 32'd0);

      // Configuration channel alone; issue channel stays quiet (R10, R2).
      @(negedge clk);
      cfg_valid       = 1'b1;
      cfg_avl         = 16'd200;
      cfg_vlmax       = 10'd128;
      cfg_grp_max_lg2 = 3'd4;
      @(posedge clk);
      #1;
      chk("R10", "cfg alone cfg_rsp_valid", 32'(cfg_rsp_valid), 32'd1);
      chk("R10", "cfg alone iss_rsp_valid", 32'(iss_rsp_valid), 32'd0);
      chk("R2", "cfg alone granted vl", 32'(cfg_rsp_vl), 32'd128);

      // Issue channel alone with a unit group and odd vl (R8, R10).
      @(negedge clk);
      cfg_valid    = 1'b0;
      iss_valid    = 1'b1;
      iss_grp_size = 6'd1;
      iss_vl       = 10'd511;
      iss_vlmax    = 10'd512;
      @(posedge clk);
      #1;
      chk("R10", "iss alone cfg_rsp_valid", 32'(cfg_rsp_valid), 32'd0);
      chk("R8", "unit group illegal",  32'(iss_rsp_illegal),  32'd0);
      chk("R8", "unit group reserved", 32'(iss_rsp_reserved), 32'd0);

      // Largest legal size, vl just short of a multiple (R7).
      @(negedge clk);
      iss_grp_size = 6'd32;
      iss_vl       = 10'd63;
      iss_vlmax    = 10'd64;
      @(posedge clk);
      #1;
      chk("R7", "size 32 vl 63 reserved", 32'(iss_rsp_reserved), 32'd1);
      chk("R7", "size 32 vl 63 illegal",  32'(iss_rsp_illegal),  32'd0);

      // Reset during traffic clears both response valids (R11).
      @(negedge clk);
      cfg_valid = 1'b1;
      rst_n     = 1'b0;
      #1;
      chk("R11", "cfg_rsp_valid mid reset", 32'(cfg_rsp_valid), 32'd0);
      chk("R11", "iss_rsp_valid mid reset", 32'(iss_rsp_valid), 32'd0);
      chk("R11", "cfg_ready mid reset",     32'(cfg_ready),     32'd0);
      @(negedge clk);
      cfg_valid = 1'b0;
      iss_valid = 1'b0;
      rst_n     = 1'b1;
      repeat (2) @(negedge clk);

      finished = 1'b1;
      summary();
      $finish;
   end

endmodule